// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port with Pin-Change Interrupt

The block is an eight-bit general-purpose I/O port on a simple register bus. Each bit is driven or read under the control of a per-bit direction setting. Bits set as outputs drive a pad with the output latch value. Bits set as inputs are sampled through a synchronizer. A visible pin register combines both sources: it shows the synchronized pad level for inputs and the latch value for outputs.

A write to the pin register's address does not load it. Instead, every one in the written value flips the matching output latch bit. This lets software toggle pins without a read-modify-write. A direction change recomputes the visible pin register in the same clock edge. It also reports which bits changed, plus one strobe that marks the new full value as valid. A write that touches the output latch gives a one-cycle strobe while the latch value is presented.

A change on a synchronized input bit whose pin-change mask bit is one sets a sticky flag. Software clears the flag by writing one to it. The interrupt line is the flag qualified by a global enable.

Top module: `gpio_port8`

Register addresses on `bus_addr`: 0 output latch, 1 direction (1 = output), 2 visible pin (read) / toggle (write), 3 pin-change mask, 4 control (bit 0 = interrupt enable), 5 status (bit 0 = pin-change flag, write 1 to clear). Other addresses read as zero and ignore writes.

## Requirements
- R1: After synchronous reset the output latch, direction, mask, enable and flag are all 0, so every pad enable is low and `irq` is low.
- R2: The visible pin value read at address 2 equals (synchronized pad input AND NOT direction) OR (output latch AND direction), bit by bit.
- R3: Writing V to address 2 replaces the output latch with its old value XOR V, whatever the direction bits are.
- R4: A write to address 1 updates the direction and the visible pin value at the same edge. In the cycle that follows, `pin_evt` holds old XOR new visible value and `pin_evt_all` is 1. In every other cycle both are 0.
- R5: A write to address 0 or 2 raises `out_evt` for exactly the next cycle, and `snap_out` then carries the new latch value.
- R6: The flag is set when a synchronized input bit differs from its previous sample and the matching bit at address 3 is 1. A change on an unmasked bit leaves the flag unchanged.
- R7: The flag stays set until a write to address 5 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R8: `irq` equals the flag AND the control enable bit (address 4, bit 0).
- R9: `pad_oe` equals the direction register and `pad_out` equals the output latch.
- R10: Addresses 0, 1, 3 and 4 read back the value last written (bit 0 only at address 4). `snap_out`, `snap_dir` and `snap_pin` show the latch, direction and visible pin registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables |
| irq | output | 1 | Pin-change interrupt request |
| out_evt | output | 1 | Output latch written strobe |
| pin_evt | output | 8 | Per-bit visible-pin change after a direction write |
| pin_evt_all | output | 1 | Visible pin value updated by a direction write |
| snap_out | output | 8 | Output latch snapshot |
| snap_dir | output | 8 | Direction snapshot |
| snap_pin | output | 8 | Visible pin snapshot |

## Verification
Register writes take effect at the capturing edge. The bench drives on falling edges and samples on the next falling edge, so readback, pad values and the `out_evt`/`pin_evt` strobes are checked half a cycle after that edge. The strobes are checked again one cycle later to confirm they have dropped. A pad input change needs two edges through the synchronizer and one more into the visible pin register and the flag. The bench therefore waits four cycles after each pad change before it reads address 2 or 5.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_LATCH = 3'd0,
    RA_DIR   = 3'd1,
    RA_PIN   = 3'd2,
    RA_MASK  = 3'd3,
    RA_CTRL  = 3'd4,
    RA_STAT  = 3'd5
  } reg_addr_e;

  // visible pin: inputs from the pad, outputs from the latch
  function automatic logic [PORT_W-1:0] pin_view(
    input logic [PORT_W-1:0] ext,
    input logic [PORT_W-1:0] latch,
    input logic [PORT_W-1:0] dir
  );
    return (ext & ~dir) | (latch & dir);
  endfunction

  // toggle write on the pin address
  function automatic logic [PORT_W-1:0] toggle_bits(
    input logic [PORT_W-1:0] latch,
    input logic [PORT_W-1:0] flip
  );
    return latch ^ flip;
  endfunction

  // which bits moved between two samples
  function automatic logic [PORT_W-1:0] edge_bits(
    input logic [PORT_W-1:0] now_v,
    input logic [PORT_W-1:0] old_v
  );
    return now_v ^ old_v;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic [PORT_W-1:0] ext_sync,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] mask_q,
  output logic              en_q,
  output logic [PORT_W-1:0] pin_q,
  output logic              latch_evt_q,
  output logic [PORT_W-1:0] pin_evt_q,
  output logic              pin_all_q,
  output logic              flag_clr
);
  logic wr_latch, wr_dir, wr_pin, wr_mask, wr_ctrl, wr_stat;
  logic [PORT_W-1:0] latch_nx, dir_nx, pin_nx;

  assign wr_latch = bus_we && (bus_addr == RA_LATCH);
  assign wr_dir   = bus_we && (bus_addr == RA_DIR);
  assign wr_pin   = bus_we && (bus_addr == RA_PIN);
  assign wr_mask  = bus_we && (bus_addr == RA_MASK);
  assign wr_ctrl  = bus_we && (bus_addr == RA_CTRL);
  assign wr_stat  = bus_we && (bus_addr == RA_STAT);
  assign flag_clr = wr_stat && bus_wdata[0];

  always_comb begin
    latch_nx = latch_q;
    if (wr_latch)    latch_nx = bus_wdata;
    else if (wr_pin) latch_nx = toggle_bits(latch_q, bus_wdata);
    dir_nx = wr_dir ? bus_wdata : dir_q;
    pin_nx = pin_view(ext_sync, latch_nx, dir_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q     <= '0;
      dir_q       <= '0;
      mask_q      <= '0;
      en_q        <= 1'b0;
      pin_q       <= '0;
      latch_evt_q <= 1'b0;
      pin_evt_q   <= '0;
      pin_all_q   <= 1'b0;
    end else begin
      latch_q     <= latch_nx;
      dir_q       <= dir_nx;
      pin_q       <= pin_nx;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_ctrl) en_q   <= bus_wdata[0];
      latch_evt_q <= wr_latch || wr_pin;
      pin_evt_q   <= wr_dir ? edge_bits(pin_nx, pin_q) : '0;
      pin_all_q   <= wr_dir;
    end
  end
endmodule

// File: rtl/gpio_pin_change.sv
module gpio_pin_change
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] ext_sync,
  input  logic [PORT_W-1:0] mask,
  input  logic              clr,
  output logic              hit,
  output logic              flag_q
);
  logic [PORT_W-1:0] prev_q;

  assign hit = |(edge_bits(ext_sync, prev_q) & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= ext_sync;
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic              irq,
  output logic              out_evt,
  output logic [PORT_W-1:0] pin_evt,
  output logic              pin_evt_all,
  output logic [PORT_W-1:0] snap_out,
  output logic [PORT_W-1:0] snap_dir,
  output logic [PORT_W-1:0] snap_pin
);
  logic [PORT_W-1:0] ext_sync, latch_q, dir_q, mask_q, pin_q;
  logic              en_q, flag_q, flag_clr, pc_hit;

  gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pad_in), .q_sync(ext_sync)
  );

  gpio_port_regs u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_sync(ext_sync), .latch_q(latch_q),
    .dir_q(dir_q), .mask_q(mask_q), .en_q(en_q), .pin_q(pin_q),
    .latch_evt_q(out_evt), .pin_evt_q(pin_evt), .pin_all_q(pin_evt_all),
    .flag_clr(flag_clr)
  );

  gpio_pin_change u_pc (
    .clk(clk), .rst(rst), .ext_sync(ext_sync), .mask(mask_q),
    .clr(flag_clr), .hit(pc_hit), .flag_q(flag_q)
  );

  always_comb begin
    unique case (bus_addr)
      RA_LATCH: bus_rdata = latch_q;
      RA_DIR:   bus_rdata = dir_q;
      RA_PIN:   bus_rdata = pin_q;
      RA_MASK:  bus_rdata = mask_q;
      RA_CTRL:  bus_rdata = {{(PORT_W-1){1'b0}}, en_q};
      RA_STAT:  bus_rdata = {{(PORT_W-1){1'b0}}, flag_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign pad_out  = latch_q;
  assign pad_oe   = dir_q;
  assign irq      = flag_q & en_q;
  assign snap_out = latch_q;
  assign snap_dir = dir_q;
  assign snap_pin = pin_q;
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk
  import gpio_port_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] snap_out,
  input logic [PORT_W-1:0] snap_dir,
  input logic [PORT_W-1:0] snap_pin,
  input logic [PORT_W-1:0] pin_evt,
  input logic              pin_evt_all,
  input logic              out_evt,
  input logic              irq,
  input logic              en_q,
  input logic              flag_q,
  input logic              pc_hit
);
  AST_TOGGLE_XOR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RA_PIN) |=> (snap_out == ($past(snap_out) ^ $past(bus_wdata)))); // R3
  AST_DIR_EVT_DIFF: assert property (@(posedge clk) disable iff (rst)
    pin_evt_all |-> (pin_evt == (snap_pin ^ $past(snap_pin)))); // R4
  AST_EVT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pin_evt_all |-> (pin_evt == '0)); // R4
  AST_LATCH_EVT: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RA_LATCH) |=> (out_evt && snap_out == $past(bus_wdata))); // R5
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
    pc_hit |=> flag_q); // R6
  AST_NO_HIT_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !pc_hit) |=> !flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(bus_we && bus_addr == RA_STAT && bus_wdata[0])) |=> flag_q); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq); // R8
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RA_DIR) |=> (snap_dir == $past(bus_wdata))); // R10
endmodule

bind gpio_port8 gpio_port8_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .snap_out(snap_out), .snap_dir(snap_dir),
  .snap_pin(snap_pin), .pin_evt(pin_evt), .pin_evt_all(pin_evt_all),
  .out_evt(out_evt), .irq(irq), .en_q(en_q), .flag_q(flag_q),
  .pc_hit(pc_hit)
);

// File: tb/gpio_port8_bench.sv
`timescale 1ns/100ps
module gpio_port8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] bus_rdata, pad_out, pad_oe, pin_evt, snap_out, snap_dir, snap_pin;
  logic       irq, out_evt, pin_evt_all;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gpio_port8 u_gpio_port8 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .out_evt(out_evt),
    .pin_evt(pin_evt), .pin_evt_all(pin_evt_all), .snap_out(snap_out),
    .snap_dir(snap_dir), .snap_pin(snap_pin)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); chk("R1 latch", v, 8'h00);
    rd(3'd1, v); chk("R1 dir", v, 8'h00);
    rd(3'd5, v); chk("R1 flag", v, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(3'd0, 8'hA5);
    chk("R5 out_evt", {7'd0, out_evt}, 8'h01);
    chk("R5 snap_out", snap_out, 8'hA5);
    idle(1);
    chk("R5 out_evt drop", {7'd0, out_evt}, 8'h00);
    rd(3'd0, v); chk("R10 latch rb", v, 8'hA5);
    chk("R9 pad_out", pad_out, 8'hA5);
    wr(3'd1, 8'h0F);
    rd(3'd1, v); chk("R10 dir rb", v, 8'h0F);
    chk("R9 pad_oe", pad_oe, 8'h0F);
    chk("R10 snap_dir", snap_dir, 8'h0F);
    wr(3'd3, 8'h81);
    rd(3'd3, v); chk("R10 mask rb", v, 8'h81);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_pinview();
    logic [7:0] v;
    pad_in = 8'h3C;
    idle(4);
    rd(3'd2, v); chk("R2 mixed view", v, (8'h3C & ~8'h0F) | (8'hA5 & 8'h0F));
    chk("R10 snap_pin", snap_pin, 8'h35);
  endtask

  task automatic t_toggle();
    logic [7:0] v;
    wr(3'd2, 8'hFF);
    chk("R3 toggle all", snap_out, 8'h5A);
    chk("R5 toggle evt", {7'd0, out_evt}, 8'h01);
    wr(3'd2, 8'h30);
    rd(3'd0, v); chk("R3 toggle input bits", v, 8'h6A);
    wr(3'd2, 8'h30);
    chk("R3 toggle back", snap_out, 8'h5A);
  endtask

  task automatic t_dir_evt();
    logic [7:0] v;
    idle(1);
    chk("R4 no evt idle", pin_evt, 8'h00);
    chk("R2 before dir", snap_pin, 8'h3A);
    wr(3'd1, 8'hF0);
    chk("R4 evt bits", pin_evt, 8'h66);
    chk("R4 evt all", {7'd0, pin_evt_all}, 8'h01);
    rd(3'd2, v); chk("R4 new view", v, 8'h5C);
    idle(1);
    chk("R4 evt drop", pin_evt, 8'h00);
    chk("R4 all drop", {7'd0, pin_evt_all}, 8'h00);
    wr(3'd1, 8'hF0);
    chk("R4 same dir no bits", pin_evt, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_pcint();
    logic [7:0] v;
    wr(3'd5, 8'h01);
    pad_in = 8'hC3;
    idle(4);
    rd(3'd5, v); chk("R6 unmasked no flag", v, 8'h00);
    wr(3'd3, 8'h01);
    pad_in = 8'h43;
    idle(4);
    rd(3'd5, v); chk("R6 other bit no flag", v, 8'h00);
    pad_in = 8'h42;
    idle(4);
    rd(3'd5, v); chk("R6 masked flag", v, 8'h01);
    chk("R8 irq off", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R10 ctrl rb", v, 8'h01);
    chk("R8 irq on", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R7 sticky", v, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R7 cleared", v, 8'h00);
    chk("R8 irq after clear", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regmap();
    t_pinview();
    t_toggle();
    t_dir_evt();
    t_pcint();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule